// File: doc/BRIEF.md
# Byte-Parity Link Monitor for a Peripheral Bus Receiver

This block sits at the receiving edge of a peripheral bus link (APB style: select, enable, ready, write direction, address, data, strobes, user sidebands and a wakeup line). Every payload signal arrives with its own odd-parity check signal. The monitor recomputes the parity of each signal group and flags a mismatch only in cycles where that group is meaningful for the current transfer phase. Parity on an idle or irrelevant signal never raises an error.

Mismatches are reported in three ways. The first is a combinational per-group pulse in the same cycle, meant for a hook that terminates the transfer. The second is a sticky status vector that is cleared by writing ones on a clear input. The third is a registered interrupt, formed from the stored status gated by a per-group enable mask. The block drives no corrective action of its own. Reset is synchronous and active high.

Top module: `apb_parity_monitor`

## Requirements
- R1: Error, status, mask and clear vectors share one 14-bit layout: bit 0 select, 1 address, 2 control (protection, non-secure extension, write direction), 3 enable, 4 write data, 5 strobe, 6 ready, 7 read data, 8 completion error, 9 wakeup, 10 request user, 11 write user, 12 read user, 13 response user.
- R2: A multi-bit group passes when each byte lane and its check bit hold an odd number of ones. Check bit n covers payload bits 8n+7..8n. When the width is not a whole number of bytes, the top check bit covers only the remaining upper bits. A single check bit covers the whole strobe vector and the 5-bit control group.
- R3: A single-bit signal passes only when its check bit is the inverse of the signal.
- R4: Address, control, enable and request-user groups are checked only while select is high.
- R5: Write-data, strobe and write-user groups are checked only while select and write are both high.
- R6: The ready group is checked only while select and enable are both high.
- R7: Read-data and read-user groups are checked only when select, enable and ready are high and write is low. Completion-error and response-user groups are checked when select, enable and ready are high.
- R8: Select and wakeup groups are checked in every cycle that reset is low. No group is checked while reset is high.
- R9: `err_now` shows the failing qualified groups in the same cycle as the offending inputs. `err_any` is their OR.
- R10: A bit of `err_status` sets on the clock edge after its group fails and then stays set. A bit is cleared at an edge where the matching `clr_bits` bit is one, unless the group fails in that same cycle, in which case the set wins.
- R11: `irq` is a register that, at each edge, takes the OR of `err_status & irq_mask` as it stood before the edge.
- R12: Reset clears `err_status` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| lnk_sel | input | 1 | Peripheral select |
| lnk_sel_chk | input | 1 | Inverse check of select |
| lnk_addr | input | ADDR_W | Address |
| lnk_addr_chk | input | ceil(ADDR_W/8) | Address byte parity |
| lnk_prot | input | 3 | Protection attributes |
| lnk_nse | input | 1 | Non-secure extension attribute |
| lnk_write | input | 1 | Write direction |
| lnk_ctrl_chk | input | 1 | Parity over protection, extension and write |
| lnk_enable | input | 1 | Access phase enable |
| lnk_enable_chk | input | 1 | Inverse check of enable |
| lnk_wdata | input | DATA_W | Write data |
| lnk_wdata_chk | input | ceil(DATA_W/8) | Write data byte parity |
| lnk_strb | input | DATA_W/8 | Write strobes |
| lnk_strb_chk | input | 1 | Parity over strobes |
| lnk_ready | input | 1 | Completer ready |
| lnk_ready_chk | input | 1 | Inverse check of ready |
| lnk_rdata | input | DATA_W | Read data |
| lnk_rdata_chk | input | ceil(DATA_W/8) | Read data byte parity |
| lnk_slverr | input | 1 | Completion error |
| lnk_slverr_chk | input | 1 | Inverse check of completion error |
| lnk_wake | input | 1 | Wakeup request |
| lnk_wake_chk | input | 1 | Inverse check of wakeup |
| lnk_auser | input | AUSER_W | Request user sideband |
| lnk_auser_chk | input | ceil(AUSER_W/8) | Request user byte parity |
| lnk_wuser | input | WUSER_W | Write user sideband |
| lnk_wuser_chk | input | ceil(WUSER_W/8) | Write user byte parity |
| lnk_ruser | input | RUSER_W | Read user sideband |
| lnk_ruser_chk | input | ceil(RUSER_W/8) | Read user byte parity |
| lnk_buser | input | BUSER_W | Response user sideband |
| lnk_buser_chk | input | ceil(BUSER_W/8) | Response user byte parity |
| clr_bits | input | 14 | Write-one-to-clear strobe for status bits |
| irq_mask | input | 14 | Per-group interrupt enable |
| err_now | output | 14 | Same-cycle qualified mismatch per group |
| err_any | output | 1 | OR of err_now |
| err_status | output | 14 | Sticky mismatch status |
| irq | output | 1 | Registered masked interrupt |

## Verification
The hardest situations to reach from the ports are two cases that need exact phase conditions. One is a corrupted read-data or read-user lane that must be flagged only in a ready, non-write access phase. The other is the same corruption arriving while the phase disqualifies it, which must leave the status untouched. The stimulus randomizes select, enable, ready and write independently in every cycle and corrupts one check bit of a random group in about a third of the cycles, so each group is corrupted under qualifying and non-qualifying phases alike. A directed prelude forces the partial top byte of the request-user group, a failure and its clear landing in the same cycle, and an inverse check corrupted during reset. A behavioural model compares every output bit on every cycle.

// File: rtl/apb_par_pkg.sv
package apb_par_pkg;

    localparam int NGRP = 14;

    // Group index: bit position in every error/status/mask/clear vector
    typedef enum logic [3:0] {
        G_SEL   = 4'd0,
        G_ADDR  = 4'd1,
        G_CTRL  = 4'd2,
        G_EN    = 4'd3,
        G_WDATA = 4'd4,
        G_STRB  = 4'd5,
        G_RDY   = 4'd6,
        G_RDATA = 4'd7,
        G_SERR  = 4'd8,
        G_WAKE  = 4'd9,
        G_AUSER = 4'd10,
        G_WUSER = 4'd11,
        G_RUSER = 4'd12,
        G_BUSER = 4'd13
    } grp_e;

    typedef logic [NGRP-1:0] grp_vec_t;

    // Handshake state that qualifies the checks
    typedef struct packed {
        logic sel;
        logic en;
        logic rdy;
        logic wr;
    } hs_t;

    // Number of byte lanes covering a payload of w bits
    function automatic int chk_w(input int w);
        return (w + 7) / 8;
    endfunction

endpackage

// File: rtl/apb_odd_byte_chk.sv
module apb_odd_byte_chk #(
    parameter  int W  = 8,
    localparam int CW = apb_par_pkg::chk_w(W)
) (
    input  logic [W-1:0]  data,
    input  logic [CW-1:0] chk,
    output logic          bad
);
    logic [CW-1:0] lane_bad;

    // One lane per check bit; the top lane may be narrower than a byte
    for (genvar i = 0; i < CW; i++) begin : g_lane
        localparam int LO = 8 * i;
        localparam int N  = ((W - LO) < 8) ? (W - LO) : 8;
        assign lane_bad[i] = ~(^{data[LO +: N], chk[i]});
    end

    assign bad = |lane_bad;

endmodule

// File: rtl/apb_chk_qual.sv
module apb_chk_qual
    import apb_par_pkg::*;
(
    input  logic     rst,
    input  hs_t      hs,
    output grp_vec_t en
);
    logic rd_done;
    logic rsp_done;

    assign rsp_done = hs.sel & hs.en & hs.rdy;
    assign rd_done  = rsp_done & ~hs.wr;

    always_comb begin
        en = '0;
        if (!rst) begin
            en[G_SEL]   = 1'b1;
            en[G_WAKE]  = 1'b1;
            en[G_ADDR]  = hs.sel;
            en[G_CTRL]  = hs.sel;
            en[G_EN]    = hs.sel;
            en[G_AUSER] = hs.sel;
            en[G_WDATA] = hs.sel & hs.wr;
            en[G_STRB]  = hs.sel & hs.wr;
            en[G_WUSER] = hs.sel & hs.wr;
            en[G_RDY]   = hs.sel & hs.en;
            en[G_RDATA] = rd_done;
            en[G_RUSER] = rd_done;
            en[G_SERR]  = rsp_done;
            en[G_BUSER] = rsp_done;
        end
    end

endmodule

// File: rtl/apb_err_track.sv
module apb_err_track
    import apb_par_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  grp_vec_t fail,
    input  grp_vec_t clr,
    input  grp_vec_t mask,
    output grp_vec_t status,
    output logic     irq
);
    grp_vec_t masked;

    assign masked = status & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= (status & ~clr) | fail;
            irq    <= |masked;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_bit_chk
        // R10
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (status[g] && !clr[g]) |=> status[g]);
        // R10
        fail_set_chk: assert property (@(posedge clk) disable iff (rst)
            fail[g] |=> status[g]);
        // R10
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !fail[g]) |=> !status[g]);
    end

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(status & mask)) |=> irq);
    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(status & mask)) |=> !irq);
    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq));

endmodule

// File: rtl/apb_parity_monitor.sv
module apb_parity_monitor
    import apb_par_pkg::*;
#(
    parameter  int ADDR_W  = 32,
    parameter  int DATA_W  = 32,
    parameter  int AUSER_W = 10,
    parameter  int WUSER_W = 4,
    parameter  int RUSER_W = 4,
    parameter  int BUSER_W = 4,
    localparam int AC  = chk_w(ADDR_W),
    localparam int DC  = chk_w(DATA_W),
    localparam int SW  = DATA_W / 8,
    localparam int UAC = chk_w(AUSER_W),
    localparam int UWC = chk_w(WUSER_W),
    localparam int URC = chk_w(RUSER_W),
    localparam int UBC = chk_w(BUSER_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lnk_sel,
    input  logic               lnk_sel_chk,
    input  logic [ADDR_W-1:0]  lnk_addr,
    input  logic [AC-1:0]      lnk_addr_chk,
    input  logic [2:0]         lnk_prot,
    input  logic               lnk_nse,
    input  logic               lnk_write,
    input  logic               lnk_ctrl_chk,
    input  logic               lnk_enable,
    input  logic               lnk_enable_chk,
    input  logic [DATA_W-1:0]  lnk_wdata,
    input  logic [DC-1:0]      lnk_wdata_chk,
    input  logic [SW-1:0]      lnk_strb,
    input  logic               lnk_strb_chk,
    input  logic               lnk_ready,
    input  logic               lnk_ready_chk,
    input  logic [DATA_W-1:0]  lnk_rdata,
    input  logic [DC-1:0]      lnk_rdata_chk,
    input  logic               lnk_slverr,
    input  logic               lnk_slverr_chk,
    input  logic               lnk_wake,
    input  logic               lnk_wake_chk,
    input  logic [AUSER_W-1:0] lnk_auser,
    input  logic [UAC-1:0]     lnk_auser_chk,
    input  logic [WUSER_W-1:0] lnk_wuser,
    input  logic [UWC-1:0]     lnk_wuser_chk,
    input  logic [RUSER_W-1:0] lnk_ruser,
    input  logic [URC-1:0]     lnk_ruser_chk,
    input  logic [BUSER_W-1:0] lnk_buser,
    input  logic [UBC-1:0]     lnk_buser_chk,
    input  logic [NGRP-1:0]    clr_bits,
    input  logic [NGRP-1:0]    irq_mask,
    output logic [NGRP-1:0]    err_now,
    output logic               err_any,
    output logic [NGRP-1:0]    err_status,
    output logic               irq
);
    hs_t      hs;
    grp_vec_t qual;
    grp_vec_t raw_bad;
    grp_vec_t fail;

    assign hs = '{sel: lnk_sel, en: lnk_enable, rdy: lnk_ready, wr: lnk_write};

    apb_chk_qual u_qual (
        .rst (rst),
        .hs  (hs),
        .en  (qual)
    );

    // Single-bit critical signals: odd parity over one bit is the inverse
    apb_odd_byte_chk #(.W(1)) u_sel (
        .data (lnk_sel), .chk (lnk_sel_chk), .bad (raw_bad[G_SEL]));
    apb_odd_byte_chk #(.W(1)) u_en (
        .data (lnk_enable), .chk (lnk_enable_chk), .bad (raw_bad[G_EN]));
    apb_odd_byte_chk #(.W(1)) u_rdy (
        .data (lnk_ready), .chk (lnk_ready_chk), .bad (raw_bad[G_RDY]));
    apb_odd_byte_chk #(.W(1)) u_serr (
        .data (lnk_slverr), .chk (lnk_slverr_chk), .bad (raw_bad[G_SERR]));
    apb_odd_byte_chk #(.W(1)) u_wake (
        .data (lnk_wake), .chk (lnk_wake_chk), .bad (raw_bad[G_WAKE]));

    // Control attributes share one check bit
    apb_odd_byte_chk #(.W(5)) u_ctrl (
        .data ({lnk_nse, lnk_write, lnk_prot}), .chk (lnk_ctrl_chk),
        .bad  (raw_bad[G_CTRL]));
    apb_odd_byte_chk #(.W(SW)) u_strb (
        .data (lnk_strb), .chk (lnk_strb_chk), .bad (raw_bad[G_STRB]));

    // Byte-lane protected payloads
    apb_odd_byte_chk #(.W(ADDR_W)) u_addr (
        .data (lnk_addr), .chk (lnk_addr_chk), .bad (raw_bad[G_ADDR]));
    apb_odd_byte_chk #(.W(DATA_W)) u_wdata (
        .data (lnk_wdata), .chk (lnk_wdata_chk), .bad (raw_bad[G_WDATA]));
    apb_odd_byte_chk #(.W(DATA_W)) u_rdata (
        .data (lnk_rdata), .chk (lnk_rdata_chk), .bad (raw_bad[G_RDATA]));
    apb_odd_byte_chk #(.W(AUSER_W)) u_auser (
        .data (lnk_auser), .chk (lnk_auser_chk), .bad (raw_bad[G_AUSER]));
    apb_odd_byte_chk #(.W(WUSER_W)) u_wuser (
        .data (lnk_wuser), .chk (lnk_wuser_chk), .bad (raw_bad[G_WUSER]));
    apb_odd_byte_chk #(.W(RUSER_W)) u_ruser (
        .data (lnk_ruser), .chk (lnk_ruser_chk), .bad (raw_bad[G_RUSER]));
    apb_odd_byte_chk #(.W(BUSER_W)) u_buser (
        .data (lnk_buser), .chk (lnk_buser_chk), .bad (raw_bad[G_BUSER]));

    assign fail    = raw_bad & qual;
    assign err_now = fail;
    assign err_any = |fail;

    apb_err_track u_track (
        .clk    (clk),
        .rst    (rst),
        .fail   (fail),
        .clr    (clr_bits),
        .mask   (irq_mask),
        .status (err_status),
        .irq    (irq)
    );

    // R7
    rdata_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (err_now[G_RDATA] || err_now[G_RUSER]) |->
            (lnk_sel && lnk_enable && lnk_ready && !lnk_write));
    // R5
    wdata_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (err_now[G_WDATA] || err_now[G_STRB] || err_now[G_WUSER]) |->
            (lnk_sel && lnk_write));
    // R4
    addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (err_now[G_ADDR] || err_now[G_CTRL] || err_now[G_AUSER]) |-> lnk_sel);
    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        rst |-> (err_now == '0));
    // R3
    sel_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        (lnk_sel_chk != lnk_sel) |-> !err_now[G_SEL]);

endmodule

// File: tb/test_apb_parity_monitor.sv
`timescale 1ns/1ps
module test_apb_parity_monitor;

    localparam int ADDR_W = 32, DATA_W = 32, AUSER_W = 10;
    localparam int WUSER_W = 4, RUSER_W = 4, BUSER_W = 4, NG = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lnk_sel, lnk_sel_chk, lnk_nse, lnk_write, lnk_ctrl_chk;
    logic lnk_enable, lnk_enable_chk, lnk_strb_chk, lnk_ready, lnk_ready_chk;
    logic lnk_slverr, lnk_slverr_chk, lnk_wake, lnk_wake_chk;
    logic [ADDR_W-1:0] lnk_addr;
    logic [3:0]        lnk_addr_chk;
    logic [2:0]        lnk_prot;
    logic [DATA_W-1:0] lnk_wdata, lnk_rdata;
    logic [3:0]        lnk_wdata_chk, lnk_rdata_chk, lnk_strb;
    logic [AUSER_W-1:0] lnk_auser;
    logic [1:0]        lnk_auser_chk;
    logic [3:0]        lnk_wuser, lnk_ruser, lnk_buser;
    logic              lnk_wuser_chk, lnk_ruser_chk, lnk_buser_chk;
    logic [NG-1:0]     clr_bits, irq_mask, err_now, err_status;
    logic              err_any, irq;

    apb_parity_monitor #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUSER_W(AUSER_W),
        .WUSER_W(WUSER_W), .RUSER_W(RUSER_W), .BUSER_W(BUSER_W)
    ) i_apb_parity_monitor (.*);

    always #4 clk = ~clk;  // 125 MHz

    int n_checks = 0;
    int n_fail   = 0;
    logic [NG-1:0] m_status = '0;
    logic          m_irq    = 1'b0;
    logic [NG-1:0] m_fail;
    logic          prev_rst = 1'b1;

    // Odd byte parity: each check bit makes its lane plus itself odd
    function automatic logic [7:0] par_of(input logic [63:0] v, input int w);
        logic [7:0] c = '0;
        for (int i = 0; i < (w + 7) / 8; i++) begin
            int cnt = 0;
            for (int b = 0; b < 8; b++)
                if (8 * i + b < w) cnt += int'(v[8 * i + b]);
            c[i] = (cnt % 2 == 0);
        end
        return c;
    endfunction

    function automatic logic bad_of(input logic [63:0] v, input logic [7:0] c, input int w);
        for (int i = 0; i < (w + 7) / 8; i++) begin
            int cnt = int'(c[i]);
            for (int b = 0; b < 8; b++)
                if (8 * i + b < w) cnt += int'(v[8 * i + b]);
            if (cnt % 2 == 0) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic string gtag(input int g);
        case (g)
            0, 9:          return "R8";
            1, 2, 3, 10:   return "R4";
            4, 5, 11:      return "R5";
            6:             return "R6";
            default:       return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic fix_chk();
        lnk_sel_chk    = ~lnk_sel;
        lnk_enable_chk = ~lnk_enable;
        lnk_ready_chk  = ~lnk_ready;
        lnk_slverr_chk = ~lnk_slverr;
        lnk_wake_chk   = ~lnk_wake;
        lnk_ctrl_chk   = par_of(64'({lnk_nse, lnk_write, lnk_prot}), 5)[0];
        lnk_strb_chk   = par_of(64'(lnk_strb), 4)[0];
        lnk_addr_chk   = par_of(64'(lnk_addr), ADDR_W)[3:0];
        lnk_wdata_chk  = par_of(64'(lnk_wdata), DATA_W)[3:0];
        lnk_rdata_chk  = par_of(64'(lnk_rdata), DATA_W)[3:0];
        lnk_auser_chk  = par_of(64'(lnk_auser), AUSER_W)[1:0];
        lnk_wuser_chk  = par_of(64'(lnk_wuser), WUSER_W)[0];
        lnk_ruser_chk  = par_of(64'(lnk_ruser), RUSER_W)[0];
        lnk_buser_chk  = par_of(64'(lnk_buser), BUSER_W)[0];
    endtask

    task automatic idle();
        {lnk_sel, lnk_enable, lnk_ready, lnk_write, lnk_slverr, lnk_wake, lnk_nse} = '0;
        lnk_prot = '0; lnk_addr = '0; lnk_wdata = '0; lnk_rdata = '0; lnk_strb = '0;
        lnk_auser = '0; lnk_wuser = '0; lnk_ruser = '0; lnk_buser = '0;
        clr_bits = '0;
        fix_chk();
    endtask

    function automatic logic [NG-1:0] model_fail();
        logic [NG-1:0] f;
        logic s = lnk_sel, e = lnk_enable, r = lnk_ready, w = lnk_write;
        f[0]  = bad_of(64'(lnk_sel), 8'(lnk_sel_chk), 1);
        f[1]  = s & bad_of(64'(lnk_addr), 8'(lnk_addr_chk), ADDR_W);
        f[2]  = s & bad_of(64'({lnk_nse, lnk_write, lnk_prot}), 8'(lnk_ctrl_chk), 5);
        f[3]  = s & bad_of(64'(lnk_enable), 8'(lnk_enable_chk), 1);
        f[4]  = s & w & bad_of(64'(lnk_wdata), 8'(lnk_wdata_chk), DATA_W);
        f[5]  = s & w & bad_of(64'(lnk_strb), 8'(lnk_strb_chk), 4);
        f[6]  = s & e & bad_of(64'(lnk_ready), 8'(lnk_ready_chk), 1);
        f[7]  = s & e & r & ~w & bad_of(64'(lnk_rdata), 8'(lnk_rdata_chk), DATA_W);
        f[8]  = s & e & r & bad_of(64'(lnk_slverr), 8'(lnk_slverr_chk), 1);
        f[9]  = bad_of(64'(lnk_wake), 8'(lnk_wake_chk), 1);
        f[10] = s & bad_of(64'(lnk_auser), 8'(lnk_auser_chk), AUSER_W);
        f[11] = s & w & bad_of(64'(lnk_wuser), 8'(lnk_wuser_chk), WUSER_W);
        f[12] = s & e & r & ~w & bad_of(64'(lnk_ruser), 8'(lnk_ruser_chk), RUSER_W);
        f[13] = s & e & r & bad_of(64'(lnk_buser), 8'(lnk_buser_chk), BUSER_W);
        return rst ? '0 : f;
    endfunction

    // Called just after a falling edge with inputs set; returns at the next falling edge
    task automatic tick();
        #2;
        m_fail = model_fail();
        for (int g = 0; g < NG; g++)
            check(gtag(g), 64'(err_now[g]), 64'(m_fail[g]));
        check("R9", 64'(err_any), 64'(|m_fail));
        check(prev_rst ? "R12" : "R10", 64'(err_status), 64'(m_status));
        check(prev_rst ? "R12" : "R11", 64'(irq), 64'(m_irq));
        @(posedge clk);
        m_irq    = rst ? 1'b0 : |(m_status & irq_mask);
        m_status = rst ? '0 : ((m_status & ~clr_bits) | m_fail);
        prev_rst = rst;
        @(negedge clk);
    endtask

    task automatic corrupt(input int g);
        case (g)
            0:  lnk_sel_chk    ^= 1'b1;
            1:  lnk_addr_chk   ^= 4'(1 << ($urandom % 4));
            2:  lnk_ctrl_chk   ^= 1'b1;
            3:  lnk_enable_chk ^= 1'b1;
            4:  lnk_wdata_chk  ^= 4'(1 << ($urandom % 4));
            5:  lnk_strb_chk   ^= 1'b1;
            6:  lnk_ready_chk  ^= 1'b1;
            7:  lnk_rdata_chk  ^= 4'(1 << ($urandom % 4));
            8:  lnk_slverr_chk ^= 1'b1;
            9:  lnk_wake_chk   ^= 1'b1;
            10: lnk_auser_chk  ^= 2'(1 << ($urandom % 2));
            11: lnk_wuser_chk  ^= 1'b1;
            12: lnk_ruser_chk  ^= 1'b1;
            default: lnk_buser_chk ^= 1'b1;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        irq_mask = '1;
        idle();
        @(negedge clk);
        // R12 / R8: reset with a broken select check
        lnk_sel_chk = lnk_sel;
        tick(); tick();
        check("R12", 64'(err_status), 64'h0);
        rst = 1'b0;
        idle();
        tick();
        // R1: address lane fault under select lands on bit 1
        lnk_sel = 1'b1; lnk_addr = 32'hA5C3_0F11; fix_chk();
        lnk_addr_chk[2] ^= 1'b1;
        #1 check("R1", 64'(err_now), 64'h0002);
        tick();
        // R2: partial top byte of the request-user group
        lnk_auser = 10'h2C7; fix_chk();
        lnk_auser_chk[1] ^= 1'b1;
        #1 check("R2", 64'(err_now), 64'h0400);
        tick();
        // R3: select check equal to select is a fault
        fix_chk(); lnk_sel_chk = lnk_sel;
        #1 check("R3", 64'(err_now), 64'h0001);
        tick();
        // R10: fault and clear on the same bit in the same cycle; set wins
        fix_chk(); lnk_addr_chk[0] ^= 1'b1; clr_bits = 14'h0002;
        tick();
        check("R10", 64'(err_status[1]), 64'h1);
        clr_bits = '1; fix_chk();
        tick();
        check("R10", 64'(err_status), 64'h0);
        clr_bits = '0;
        // R7: read data fault ignored during a write access phase
        lnk_enable = 1'b1; lnk_ready = 1'b1; lnk_write = 1'b1; fix_chk();
        lnk_rdata_chk[3] ^= 1'b1;
        tick(); tick();
        check("R7", 64'(err_status[7]), 64'h0);
        // Randomized phases and faults
        for (int c = 0; c < 4000; c++) begin
            {lnk_sel, lnk_enable, lnk_ready, lnk_write} = 4'($urandom);
            {lnk_slverr, lnk_wake, lnk_nse} = 3'($urandom);
            lnk_prot = 3'($urandom); lnk_addr = $urandom;
            lnk_wdata = $urandom; lnk_rdata = $urandom; lnk_strb = 4'($urandom);
            lnk_auser = 10'($urandom); lnk_wuser = 4'($urandom);
            lnk_ruser = 4'($urandom); lnk_buser = 4'($urandom);
            fix_chk();
            if ($urandom % 3 == 0) corrupt(int'($urandom % NG));
            if ($urandom % 5 == 0) corrupt(int'($urandom % NG));
            clr_bits = ($urandom % 6 == 0) ? 14'($urandom) : '0;
            if (c % 97 == 0) irq_mask = 14'($urandom);
            rst = ($urandom % 250 == 0);
            tick();
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule